// File: doc/BRIEF.md
# Byte-Serial Command Length Counter

This block holds the 32-bit length value that sets how many test clock cycles or scan bits the next command of a test-bus engine will run. The host reaches it through one 8-bit register slot. Four byte writes build the full value, and four byte reads return it. In both directions the least significant byte comes first. A loaded flag shows whether a complete four-byte load has landed since the last time a command used the value.

Toward the command engine, the block takes a one-cycle command-start pulse and a busy level. On the start pulse it copies the counter into a count register that the engine owns, and it clears the loaded flag. While a command is running, the host cannot change the counter. Reads stay allowed at all times. The read and write directions each keep their own byte index. An access in one direction sends the other direction's index back to byte 0.

Top module: `byteCountPort`

## Requirements
- R1: After reset the counter, both byte indices, the engine count and the loaded flag are all zero, so the first four reads return 0x00.
- R2: A write strobe is accepted when `hostSel` and `hostWr` are high and neither `cmdBusy` nor `cmdStart` is high. Four accepted writes fill bytes 0 to 3 in that order, where byte 0 is bits 7:0. `ctrLoaded` goes to 1 on the clock edge that takes the fourth byte.
- R3: `ctrLoaded` stays 0 while a load is partly done. An accepted write to byte 0 clears `ctrLoaded` on the same edge.
- R4: A read is effective when `hostSel` and `hostRd` are high and `hostWr` is low. During that cycle `hostRData` shows the byte at the read index. Successive reads give bytes 0, 1, 2, 3 and then wrap to byte 0. Reads never change `ctrLoaded`.
- R5: A write strobe that arrives while `cmdBusy` is high, or in the same cycle as `cmdStart`, is discarded. It changes neither the counter, nor either index, nor `ctrLoaded`.
- R6: On the edge where `cmdStart` is high, `engCount` takes the full counter value. At all other times `engCount` holds its value.
- R7: `ctrLoaded` is 0 on the edge after `cmdStart`.
- R8: An accepted write returns the read index to byte 0. An effective read returns the write index to byte 0, which abandons any partial load.
- R9: `hostRData` is 0x00 whenever no read is effective. This includes a cycle with both strobes high: that cycle counts only as a write. Strobes with `hostSel` low do nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostSel | input | 1 | Host has selected the counter register |
| hostWr | input | 1 | Host write strobe, one cycle per byte |
| hostRd | input | 1 | Host read strobe, one cycle per byte |
| hostWData | input | 8 | Write byte |
| hostRData | output | 8 | Read byte, valid during an effective read |
| cmdStart | input | 1 | Command begins this cycle |
| cmdBusy | input | 1 | Command in progress, writes locked out |
| engCount | output | 32 | Count latched for the running command |
| ctrLoaded | output | 1 | Full four-byte load present and not yet consumed |

## Verification
The bench goes after the places where byte order and the two index pointers can go wrong.

- **Wrapping the read index:** reading past the fourth byte checks for the wrap back to byte 0. A design that fails to wrap returns stale or shifted bytes.
- **Abandoning a partial load:** a read in the middle of a load must restart the write index. A design that skips this puts the next bytes into the wrong lanes and sets the loaded flag too early.
- **Discarded writes:** writes sent while busy, or in the same cycle as the start pulse, must leave no trace. A design that lets them through corrupts the counter or moves an index.
- **Loaded flag:** the bench checks that one new byte-0 write clears the flag, and that a start pulse consumes it. A design with a sticky flag would report a stale count as fresh.

// File: rtl/bcpPkg.sv
package bcpPkg;
  localparam int COUNT_W = 32;
  localparam int BYTE_W  = 8;
  localparam int LANES   = COUNT_W / BYTE_W;
  localparam int IDX_W   = $clog2(LANES);

  typedef struct packed {
    logic             wrEn;
    logic [IDX_W-1:0] wrSel;
    logic             rdEn;
    logic [IDX_W-1:0] rdSel;
    logic             capture;
  } ctrlStrobes_t;
endpackage

// File: rtl/bcpControl.sv
module bcpControl
  import bcpPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         hostSel,
  input  logic         hostWr,
  input  logic         hostRd,
  input  logic         cmdStart,
  input  logic         cmdBusy,
  output ctrlStrobes_t strobes,
  output logic         ctrLoaded
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LANES - 1);

  logic [IDX_W-1:0] wrIdx, rdIdx;
  logic wrAccept, rdAccept, wrLast, rdLast;

  assign wrAccept = hostSel && hostWr && !cmdBusy && !cmdStart;
  assign rdAccept = hostSel && hostRd && !hostWr;
  assign wrLast   = (wrIdx == LAST_IDX);
  assign rdLast   = (rdIdx == LAST_IDX);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrIdx <= '0;
      rdIdx <= '0;
    end else if (wrAccept) begin
      wrIdx <= wrLast ? '0 : wrIdx + 1'b1;
      rdIdx <= '0;
    end else if (rdAccept) begin
      rdIdx <= rdLast ? '0 : rdIdx + 1'b1;
      wrIdx <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                         ctrLoaded <= 1'b0;
    else if (cmdStart)                 ctrLoaded <= 1'b0;
    else if (wrAccept && wrLast)       ctrLoaded <= 1'b1;
    else if (wrAccept && wrIdx == '0)  ctrLoaded <= 1'b0;
  end

  always_comb begin
    strobes.wrEn    = wrAccept;
    strobes.wrSel   = wrIdx;
    strobes.rdEn    = rdAccept;
    strobes.rdSel   = rdIdx;
    strobes.capture = cmdStart;
  end
endmodule

// File: rtl/bcpDatapath.sv
module bcpDatapath
  import bcpPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strobes,
  input  logic [BYTE_W-1:0]  wData,
  output logic [BYTE_W-1:0]  rData,
  output logic [COUNT_W-1:0] engCount
);
  logic [BYTE_W-1:0]  lane [LANES];
  logic [COUNT_W-1:0] counterVal;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    always_ff @(posedge clk) begin
      if (!rstN)
        lane[g] <= '0;
      else if (strobes.wrEn && strobes.wrSel == IDX_W'(g))
        lane[g] <= wData;
    end
    assign counterVal[g*BYTE_W +: BYTE_W] = lane[g];
  end

  always_ff @(posedge clk) begin
    if (!rstN)                engCount <= '0;
    else if (strobes.capture) engCount <= counterVal;
  end

  assign rData = strobes.rdEn ? lane[strobes.rdSel] : '0;
endmodule

// File: rtl/byteCountPort.sv
module byteCountPort
  import bcpPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               hostSel,
  input  logic               hostWr,
  input  logic               hostRd,
  input  logic [BYTE_W-1:0]  hostWData,
  output logic [BYTE_W-1:0]  hostRData,
  input  logic               cmdStart,
  input  logic               cmdBusy,
  output logic [COUNT_W-1:0] engCount,
  output logic               ctrLoaded
);
  ctrlStrobes_t strobes;

  bcpControl u_ctl (
    .clk(clk), .rstN(rstN), .hostSel(hostSel), .hostWr(hostWr), .hostRd(hostRd),
    .cmdStart(cmdStart), .cmdBusy(cmdBusy), .strobes(strobes), .ctrLoaded(ctrLoaded)
  );

  bcpDatapath u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wData(hostWData),
    .rData(hostRData), .engCount(engCount)
  );
endmodule

// File: rtl/bcpChecker.sv
module bcpChecker
  import bcpPkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               hostSel,
  input logic               hostWr,
  input logic               hostRd,
  input logic [BYTE_W-1:0]  hostRData,
  input logic               cmdStart,
  input logic               cmdBusy,
  input logic [COUNT_W-1:0] engCount,
  input logic               ctrLoaded
);
  AST_LOADED_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctrLoaded) |-> $past(hostSel && hostWr && !cmdBusy && !cmdStart)); // R2
  AST_READ_KEEPS_LOADED: assert property (@(posedge clk) disable iff (!rstN)
    (hostSel && hostRd && !hostWr && !cmdStart) |=> $stable(ctrLoaded)); // R4
  AST_BUSY_WRITE_NO_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (cmdBusy && hostSel && hostWr && !ctrLoaded) |=> !ctrLoaded); // R5
  AST_COUNT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !cmdStart |=> $stable(engCount)); // R6
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    cmdStart |=> !ctrLoaded); // R7
  AST_IDLE_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !(hostSel && hostRd && !hostWr) |-> hostRData == '0); // R9
endmodule

bind byteCountPort bcpChecker u_chk (.*);

// File: tb/sim_byteCountPort.sv
`timescale 1ns/1ps
module sim_byteCountPort;
  logic clk = 0, rstN = 0;
  logic hostSel = 0, hostWr = 0, hostRd = 0, cmdStart = 0, cmdBusy = 0;
  logic [7:0] hostWData = 0;
  logic [7:0] hostRData;
  logic [31:0] engCount;
  logic ctrLoaded;
  int checks = 0, failures = 0;
  bit done = 0;
  logic [7:0] expQ[$];
  string tagQ[$];

  always #10 clk = ~clk;

  byteCountPort u0 (.*);

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: compare each effective read against the scoreboard
  always @(negedge clk) begin
    if (rstN && hostSel && hostRd && !hostWr) begin
      if (expQ.size() == 0) check(0, "R4 unexpected read", {24'h0, hostRData}, 32'h0);
      else begin
        logic [7:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(hostRData === e, t, {24'h0, hostRData}, {24'h0, e});
      end
    end
  end

  task automatic wrByte(input logic [7:0] d);
    @(posedge clk); #1 hostSel = 1; hostWr = 1; hostWData = d;
    @(posedge clk); #1 hostSel = 0; hostWr = 0;
  endtask

  task automatic rdByte(input logic [7:0] e, input string tag);
    expQ.push_back(e); tagQ.push_back(tag);
    @(posedge clk); #1 hostSel = 1; hostRd = 1;
    @(posedge clk); #1 hostSel = 0; hostRd = 0;
  endtask

  task automatic rd4(input logic [31:0] v, input string tag);
    for (int i = 0; i < 4; i++) rdByte(v[i*8 +: 8], tag);
  endtask

  task automatic wr4(input logic [31:0] v);
    for (int i = 0; i < 4; i++) wrByte(v[i*8 +: 8]);
  endtask

  task automatic startCmd(input bit withWrite, input logic [7:0] d);
    @(posedge clk); #1 cmdStart = 1;
    if (withWrite) begin hostSel = 1; hostWr = 1; hostWData = d; end
    @(posedge clk); #1 cmdStart = 0; hostSel = 0; hostWr = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    @(negedge clk);
    check(ctrLoaded === 0, "R1 loaded after reset", ctrLoaded, 0);
    check(engCount === 0, "R1 engCount after reset", engCount, 0);
    check(hostRData === 0, "R9 idle rdata", hostRData, 0);
    rd4(32'h0, "R1 reset read");

    // R2/R3 full load
    wrByte(8'h11); wrByte(8'h22); wrByte(8'h33);
    @(negedge clk); check(ctrLoaded === 0, "R3 partial load", ctrLoaded, 0);
    wrByte(8'h44);
    @(negedge clk); check(ctrLoaded === 1, "R2 loaded after 4th", ctrLoaded, 1);
    rd4(32'h44332211, "R4 read LSB first");
    rdByte(8'h11, "R4 read wrap");
    @(negedge clk); check(ctrLoaded === 1, "R4 reads keep loaded", ctrLoaded, 1);
    rdByte(8'h22, "R4 read continue"); rdByte(8'h33, "R4"); rdByte(8'h44, "R4");

    // R6/R7 command start
    startCmd(0, 8'h0);
    @(negedge clk);
    check(engCount === 32'h44332211, "R6 latch", engCount, 32'h44332211);
    check(ctrLoaded === 0, "R7 start clears loaded", ctrLoaded, 0);

    // R5 writes while busy discarded
    @(posedge clk); #1 cmdBusy = 1;
    wr4(32'hAABBCCDD);
    @(negedge clk); check(ctrLoaded === 0, "R5 busy no load", ctrLoaded, 0);
    check(engCount === 32'h44332211, "R6 engCount holds", engCount, 32'h44332211);
    rd4(32'h44332211, "R5 busy writes discarded");
    @(posedge clk); #1 cmdBusy = 0;

    // R5 write in start cycle discarded
    startCmd(1, 8'hEE);
    rd4(32'h44332211, "R5 start-cycle write discarded");

    // R8 partial load abandoned by read
    wrByte(8'h55); wrByte(8'h66);
    rdByte(8'h55, "R8 write resets read index");
    wr4(32'h04030201);
    @(negedge clk); check(ctrLoaded === 1, "R8 restarted load", ctrLoaded, 1);
    rd4(32'h04030201, "R8 restarted load lanes");

    // R3 new first byte clears loaded
    wrByte(8'h99);
    @(negedge clk); check(ctrLoaded === 0, "R3 byte0 clears loaded", ctrLoaded, 0);
    wrByte(8'h88); wrByte(8'h77); wrByte(8'h66);
    @(negedge clk); check(ctrLoaded === 1, "R2 reload", ctrLoaded, 1);

    // R9 both strobes: write wins, rdata zero; sel low ignored
    @(posedge clk); #1 hostSel = 1; hostWr = 1; hostRd = 1; hostWData = 8'hAB;
    @(negedge clk); check(hostRData === 0, "R9 both strobes rdata", hostRData, 0);
    @(posedge clk); #1 hostSel = 0; hostWr = 0; hostRd = 0;
    @(negedge clk); check(ctrLoaded === 0, "R9 both strobes as write", ctrLoaded, 0);
    @(posedge clk); #1 hostWr = 1; hostWData = 8'h5A;
    @(posedge clk); #1 hostWr = 0; hostRd = 1;
    @(negedge clk); check(hostRData === 0, "R9 unselected read", hostRData, 0);
    @(posedge clk); #1 hostRd = 0;
    wrByte(8'hCD); wrByte(8'hCD); wrByte(8'hCD);
    startCmd(0, 8'h0);
    @(negedge clk);
    check(engCount === 32'hCDCDCDAB, "R9 unselected write ignored", engCount, 32'hCDCDCDAB);
    check(expQ.size() == 0, "R4 all reads seen", expQ.size(), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule